// File: doc/BRIEF.md
# Flexible PPS Command Controller

This block drives a programmable pulse-per-second style output under the control of short software commands. Software writes a 4-bit command code. The controller arms itself to start either one pulse or a repeating train when the running system time reaches a programmed target time. A running train can be halted at once, or halted when the system time reaches a target. A start or stop that has not yet happened can be withdrawn.

System time and target time each arrive as a seconds part and a nanoseconds part. Pulse high time and train period are given in clock ticks. A 2-bit target mode chooses what a target-time match does:

- raise a one-cycle interrupt only,
- control the pulse output only,
- do both, or
- do nothing.

The command slot clears itself one cycle after a command is taken. The busy output tells software when the slot is free again. All inputs belong to the block's own clock domain.

Top module: `pps_cmd_ctrl`

## Requirements
- R1: After reset, `pps_out`, `tgt_irq` and `cmd_busy` are all low.
- R2: A write on `cmd_wr` with non-zero `cmd_wdata` is taken only while `cmd_busy` is low. `cmd_busy` is then high for exactly one cycle, during which the command executes. A write made while `cmd_busy` is high is discarded.
- R3: Code 1 arms a single pulse. On the first clock edge with a target match while `tgt_mode[1]` is 1, `pps_out` goes high and stays high for exactly `pulse_width` cycles, once.
- R4: Code 2 arms a train. On the match edge `pps_out` rises and then repeats with a period of `train_period` cycles, high for the first `pulse_width` cycles of each period.
- R5: Code 3, executed while a single pulse or train is armed and the target is not yet matched, returns the block to idle, so that no pulse follows a later match.
- R6: Code 4 on a running train arms a stop. The train continues until a target match (with `tgt_mode[1]` set), after which `pps_out` stays low.
- R7: Code 5 on a running train forces `pps_out` low on the edge that executes it, and keeps it low.
- R8: Code 6, executed while a stop is armed and the target is not matched, cancels the stop, and the train keeps running past the target time.
- R9: Codes 7 to 15 clear from the slot like any command but change nothing. A command that does not apply to the present state is also ignored.
- R10: In `tgt_mode` 0 a match raises the interrupt only. In mode 2 it raises the interrupt and controls the pulse. In mode 3 it controls the pulse only. In mode 1 it does neither.
- R11: A target match means system seconds are greater than target seconds, or the seconds are equal and system nanoseconds are greater than or equal to target nanoseconds.
- R12: `tgt_irq` is a one-cycle pulse, issued on the edge after the match condition goes from false to true (when the mode enables it). A match that stays true raises no further pulse.
- R13: A `pulse_width` of 0 produces no high time. A single pulse with width 0 still completes and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_sec | input | SEC_W | Running system time, seconds part |
| sys_ns | input | NS_W | Running system time, nanoseconds part |
| tgt_sec | input | SEC_W | Target time, seconds part |
| tgt_ns | input | NS_W | Target time, nanoseconds part |
| pulse_width | input | TICK_W | High time of each pulse, in clock cycles |
| train_period | input | TICK_W | Period of the train, in clock cycles |
| tgt_mode | input | 2 | Routing of a target match: 0 irq, 1 none, 2 irq and pulse, 3 pulse |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 4 | Command code written with the strobe |
| pps_out | output | 1 | Pulse output |
| tgt_irq | output | 1 | One-cycle target-match interrupt |
| cmd_busy | output | 1 | Command slot holds an unexecuted command |

## Verification
The assertions take for granted the following about the inputs:

- `pulse_width` and `train_period` stay constant while a pulse or train is running.
- `pulse_width` is below `train_period`.
- `tgt_mode` is not changed in the cycle in which a match interrupt is being raised.

The stimulus respects all of these. It changes widths, periods and modes only right after a reset or while the controller is idle or merely armed. It moves the system time and target time only on falling clock edges, by jumping between values chosen on either side of the match boundary.

// File: rtl/pps_cmd_pkg.sv
package pps_cmd_pkg;

   localparam int CMD_W = 4;

   localparam logic [CMD_W-1:0] CMD_NONE         = 4'd0;
   localparam logic [CMD_W-1:0] CMD_START_ONE    = 4'd1;
   localparam logic [CMD_W-1:0] CMD_START_TRAIN  = 4'd2;
   localparam logic [CMD_W-1:0] CMD_CANCEL_START = 4'd3;
   localparam logic [CMD_W-1:0] CMD_STOP_AT      = 4'd4;
   localparam logic [CMD_W-1:0] CMD_STOP_NOW     = 4'd5;
   localparam logic [CMD_W-1:0] CMD_CANCEL_STOP  = 4'd6;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM_ONE,
      ST_ARM_TRAIN,
      ST_PULSE,
      ST_TRAIN,
      ST_TRAIN_STOP
   } pps_state_e;

   function automatic logic is_running(pps_state_e s);
      return (s == ST_PULSE) || (s == ST_TRAIN) || (s == ST_TRAIN_STOP);
   endfunction

endpackage

// File: rtl/pps_time_cmp.sv
module pps_time_cmp #(
   parameter int SEC_W = 32,
   parameter int NS_W  = 30
) (
   input  logic [SEC_W-1:0] sys_sec,
   input  logic [NS_W-1:0]  sys_ns,
   input  logic [SEC_W-1:0] tgt_sec,
   input  logic [NS_W-1:0]  tgt_ns,
   output logic             reached
);

   generate
      if (SEC_W < 1 || NS_W < 1) begin : g_bad_width
         $error("pps_time_cmp: time widths must be positive");
      end
   endgenerate

   logic sec_gt;
   logic sec_eq;
   logic ns_ge;

   assign sec_gt  = sys_sec > tgt_sec;
   assign sec_eq  = sys_sec == tgt_sec;
   assign ns_ge   = sys_ns >= tgt_ns;
   assign reached = sec_gt | (sec_eq & ns_ge);

   always_comb begin
      AST_MATCH_ORDER: assert (!(sys_sec < tgt_sec) || !reached); // R11
   end

endmodule

// File: rtl/pps_cmd_slot.sv
module pps_cmd_slot #(
   parameter int CMD_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CMD_W-1:0] wdata,
   output logic [CMD_W-1:0] cmd,
   output logic             busy
);

   generate
      if (CMD_W < 3) begin : g_bad_cmd
         $error("pps_cmd_slot: command field too narrow");
      end
   endgenerate

   logic [CMD_W-1:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (slot_q != '0) begin
         slot_q <= '0;
      end else if (wr) begin
         slot_q <= wdata;
      end
   end

   assign cmd  = slot_q;
   assign busy = slot_q != '0;

   AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy); // R2

endmodule

// File: rtl/pps_pulse_gen.sv
module pps_pulse_gen #(
   parameter int TICK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              hold,
   input  logic              train,
   input  logic [TICK_W-1:0] width,
   input  logic [TICK_W-1:0] period,
   output logic              pps,
   output logic              width_done
);

   localparam int CW = TICK_W + 1;

   generate
      if (TICK_W < 2) begin : g_bad_tick
         $error("pps_pulse_gen: tick counter too narrow");
      end
   endgenerate

   logic [TICK_W-1:0] cnt_q;
   logic [CW-1:0]     inc;
   logic              wrap;
   logic [TICK_W-1:0] cnt_nxt;
   logic              pps_q;

   assign inc        = {1'b0, cnt_q} + CW'(1);
   assign wrap       = train && (inc >= {1'b0, period});
   assign cnt_nxt    = wrap ? '0 : inc[TICK_W-1:0];
   assign width_done = inc >= {1'b0, width};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pps_q <= 1'b0;
      end else if (start) begin
         cnt_q <= '0;
         pps_q <= width != '0;
      end else if (hold) begin
         cnt_q <= cnt_nxt;
         pps_q <= cnt_nxt < width;
      end else begin
         cnt_q <= '0;
         pps_q <= 1'b0;
      end
   end

   assign pps = pps_q;

   AST_HIGH_WITHIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      pps_q |-> (cnt_q < width)); // R13

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (train && hold && !start) |-> (cnt_q < period)); // R4

endmodule

// File: rtl/pps_cmd_ctrl.sv
module pps_cmd_ctrl
   import pps_cmd_pkg::*;
#(
   parameter int SEC_W   = 32,
   parameter int NS_W    = 30,
   parameter int TICK_W  = 16,
   parameter bit CMP_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEC_W-1:0]  sys_sec,
   input  logic [NS_W-1:0]   sys_ns,
   input  logic [SEC_W-1:0]  tgt_sec,
   input  logic [NS_W-1:0]   tgt_ns,
   input  logic [TICK_W-1:0] pulse_width,
   input  logic [TICK_W-1:0] train_period,
   input  logic [1:0]        tgt_mode,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_wdata,
   output logic              pps_out,
   output logic              tgt_irq,
   output logic              cmd_busy
);

   logic       match_raw;
   logic       match;
   logic       match_q;
   logic       irq_q;
   logic       ctl_en;
   logic       irq_en;
   logic [CMD_W-1:0] cmd;
   pps_state_e state_q;
   pps_state_e state_nxt;
   logic       start_pulse;
   logic       hold_pulse;
   logic       width_done;
   logic       pps_int;

   pps_time_cmp #(.SEC_W(SEC_W), .NS_W(NS_W)) u_cmp (
      .sys_sec (sys_sec),
      .sys_ns  (sys_ns),
      .tgt_sec (tgt_sec),
      .tgt_ns  (tgt_ns),
      .reached (match_raw)
   );

   generate
      if (CMP_REG) begin : g_cmp_reg
         logic match_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) match_r <= 1'b0;
            else        match_r <= match_raw;
         end
         assign match = match_r;
      end else begin : g_cmp_comb
         assign match = match_raw;
      end
   endgenerate

   pps_cmd_slot #(.CMD_W(CMD_W)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cmd_wr),
      .wdata (cmd_wdata),
      .cmd   (cmd),
      .busy  (cmd_busy)
   );

   assign ctl_en = tgt_mode[1];
   assign irq_en = !tgt_mode[0];

   always_comb begin
      state_nxt   = state_q;
      start_pulse = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (cmd == CMD_START_ONE)        state_nxt = ST_ARM_ONE;
            else if (cmd == CMD_START_TRAIN) state_nxt = ST_ARM_TRAIN;
         end
         ST_ARM_ONE: begin
            if (ctl_en && match) begin
               state_nxt   = ST_PULSE;
               start_pulse = 1'b1;
            end else if (cmd == CMD_CANCEL_START && !match) begin
               state_nxt = ST_IDLE;
            end
         end
         ST_ARM_TRAIN: begin
            if (ctl_en && match) begin
               state_nxt   = ST_TRAIN;
               start_pulse = 1'b1;
            end else if (cmd == CMD_CANCEL_START && !match) begin
               state_nxt = ST_IDLE;
            end
         end
         ST_PULSE: begin
            if (width_done) state_nxt = ST_IDLE;
         end
         ST_TRAIN: begin
            if (cmd == CMD_STOP_NOW)     state_nxt = ST_IDLE;
            else if (cmd == CMD_STOP_AT) state_nxt = ST_TRAIN_STOP;
         end
         ST_TRAIN_STOP: begin
            if (cmd == CMD_STOP_NOW)                     state_nxt = ST_IDLE;
            else if (ctl_en && match)                    state_nxt = ST_IDLE;
            else if (cmd == CMD_CANCEL_STOP && !match)   state_nxt = ST_TRAIN;
         end
         default: state_nxt = ST_IDLE;
      endcase
   end

   assign hold_pulse = is_running(state_nxt) && !start_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         match_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         state_q <= state_nxt;
         match_q <= match;
         irq_q   <= irq_en && match && !match_q;
      end
   end

   pps_pulse_gen #(.TICK_W(TICK_W)) u_pulse (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_pulse),
      .hold       (hold_pulse),
      .train      (state_nxt != ST_PULSE),
      .width      (pulse_width),
      .period     (train_period),
      .pps        (pps_int),
      .width_done (width_done)
   );

   assign pps_out = pps_int;
   assign tgt_irq = irq_q;

   AST_PPS_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      pps_int |-> is_running(state_q)); // R7

   AST_START_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PULSE && $past(state_q) == ST_ARM_ONE) |-> $past(match && ctl_en)); // R3

   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_irq |=> !tgt_irq); // R12

   AST_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_irq |-> !$past(tgt_mode[0])); // R10

endmodule

// File: tb/pps_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module pps_cmd_ctrl_tb;

   localparam int SEC_W  = 32;
   localparam int NS_W   = 30;
   localparam int TICK_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [SEC_W-1:0]  sys_sec = '0;
   logic [NS_W-1:0]   sys_ns = '0;
   logic [SEC_W-1:0]  tgt_sec = '0;
   logic [NS_W-1:0]   tgt_ns = '0;
   logic [TICK_W-1:0] pulse_width = '0;
   logic [TICK_W-1:0] train_period = '0;
   logic [1:0]        tgt_mode = 2'd3;
   logic              cmd_wr = 1'b0;
   logic [3:0]        cmd_wdata = '0;
   logic              pps_out;
   logic              tgt_irq;
   logic              cmd_busy;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   pps_cmd_ctrl #(.SEC_W(SEC_W), .NS_W(NS_W), .TICK_W(TICK_W)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .sys_sec      (sys_sec),
      .sys_ns       (sys_ns),
      .tgt_sec      (tgt_sec),
      .tgt_ns       (tgt_ns),
      .pulse_width  (pulse_width),
      .train_period (train_period),
      .tgt_mode     (tgt_mode),
      .cmd_wr       (cmd_wr),
      .cmd_wdata    (cmd_wdata),
      .pps_out      (pps_out),
      .tgt_irq      (tgt_irq),
      .cmd_busy     (cmd_busy)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input int w, input int p, input logic [1:0] m);
      rst_n        = 1'b0;
      sys_sec      = 0;
      sys_ns       = 0;
      tgt_sec      = 5;
      tgt_ns       = 100;
      pulse_width  = TICK_W'(w);
      train_period = TICK_W'(p);
      tgt_mode     = m;
      cmd_wr       = 1'b0;
      cmd_wdata    = '0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
   endtask

   task automatic wr(input logic [3:0] c);
      cmd_wr    = 1'b1;
      cmd_wdata = c;
      tick(1);
      cmd_wr    = 1'b0;
      cmd_wdata = '0;
   endtask

   task automatic set_sys(input int s, input int ns);
      sys_sec = SEC_W'(s);
      sys_ns  = NS_W'(ns);
   endtask

   task automatic count_high(input int n, output int h);
      h = 0;
      for (int i = 0; i < n; i++) begin
         if (pps_out) h++;
         tick(1);
      end
   endtask

   task automatic t_reset_state();
      do_reset(4, 10, 2'd3);
      chk(pps_out == 1'b0, "R1 pps after reset", int'(pps_out), 0);
      chk(tgt_irq == 1'b0, "R1 irq after reset", int'(tgt_irq), 0);
      chk(cmd_busy == 1'b0, "R1 busy after reset", int'(cmd_busy), 0);
   endtask

   task automatic t_match_compare();
      do_reset(4, 10, 2'd0);
      set_sys(5, 99);  tick(1);
      chk(tgt_irq == 1'b0, "R11 ns below target", int'(tgt_irq), 0);
      set_sys(4, 999); tick(1);
      chk(tgt_irq == 1'b0, "R11 sec below target", int'(tgt_irq), 0);
      set_sys(6, 0);   tick(1);
      chk(tgt_irq == 1'b1, "R11 sec above target", int'(tgt_irq), 1);
      tick(1);
      chk(tgt_irq == 1'b0, "R12 irq one cycle while match held", int'(tgt_irq), 0);
      set_sys(5, 99);  tick(1);
      chk(tgt_irq == 1'b0, "R11 fall below", int'(tgt_irq), 0);
      set_sys(5, 100); tick(1);
      chk(tgt_irq == 1'b1, "R11 equal time matches", int'(tgt_irq), 1);
      tick(3);
      chk(tgt_irq == 1'b0, "R12 no repeat irq", int'(tgt_irq), 0);
   endtask

   task automatic t_single();
      int h;
      do_reset(4, 10, 2'd3);
      wr(4'd1);
      chk(cmd_busy == 1'b1, "R2 busy after write", int'(cmd_busy), 1);
      tick(1);
      chk(cmd_busy == 1'b0, "R2 busy self clears", int'(cmd_busy), 0);
      set_sys(5, 100);
      chk(pps_out == 1'b0, "R3 low before match edge", int'(pps_out), 0);
      tick(1);
      chk(pps_out == 1'b1, "R3 rises on match edge", int'(pps_out), 1);
      chk(tgt_irq == 1'b0, "R10 mode 3 no irq", int'(tgt_irq), 0);
      count_high(30, h);
      chk(h == 4, "R3 single pulse width", h, 4);
   endtask

   task automatic t_busy();
      int h;
      do_reset(4, 10, 2'd3);
      cmd_wr = 1'b1; cmd_wdata = 4'd1;
      tick(1);
      cmd_wdata = 4'd2;
      tick(1);
      cmd_wr = 1'b0; cmd_wdata = '0;
      chk(cmd_busy == 1'b0, "R2 write while busy dropped", int'(cmd_busy), 0);
      set_sys(5, 100);
      count_high(40, h);
      chk(h == 4, "R2 first command kept (single)", h, 4);
   endtask

   task automatic t_train_stop_now();
      int bad = 0;
      int h;
      do_reset(3, 8, 2'd3);
      wr(4'd2); tick(1);
      set_sys(5, 100); tick(1);
      for (int k = 0; k < 32; k++) begin
         if (pps_out != ((k % 8) < 3)) bad++;
         tick(1);
      end
      chk(bad == 0, "R4 train pattern mismatches", bad, 0);
      wr(4'd5); tick(1);
      chk(pps_out == 1'b0, "R7 low on stop edge", int'(pps_out), 0);
      count_high(20, h);
      chk(h == 0, "R7 stays low", h, 0);
   endtask

   task automatic t_stop_at();
      int h;
      do_reset(3, 8, 2'd3);
      wr(4'd2); tick(1);
      set_sys(5, 100); tick(1);
      tgt_sec = 6; tgt_ns = 0;
      wr(4'd4); tick(1);
      count_high(16, h);
      chk(h == 6, "R6 train runs before stop time", h, 6);
      set_sys(6, 0); tick(1);
      count_high(20, h);
      chk(h == 0, "R6 stopped at time", h, 0);
   endtask

   task automatic t_cancel_stop();
      int h;
      do_reset(3, 8, 2'd3);
      wr(4'd2); tick(1);
      set_sys(5, 100); tick(1);
      tgt_sec = 7; tgt_ns = 0;
      wr(4'd4); tick(1);
      wr(4'd6); tick(1);
      set_sys(7, 0); tick(1);
      count_high(16, h);
      chk(h == 6, "R8 train continues past stop time", h, 6);
   endtask

   task automatic t_cancel_start();
      int h;
      do_reset(4, 10, 2'd3);
      wr(4'd1); tick(1);
      wr(4'd3); tick(1);
      set_sys(5, 100);
      count_high(20, h);
      chk(h == 0, "R5 single cancelled", h, 0);
      set_sys(0, 0);
      wr(4'd2); tick(1);
      wr(4'd3); tick(1);
      set_sys(5, 100);
      count_high(20, h);
      chk(h == 0, "R5 train cancelled", h, 0);
   endtask

   task automatic t_reserved();
      int h;
      do_reset(4, 10, 2'd3);
      wr(4'd9);
      chk(cmd_busy == 1'b1, "R9 reserved code taken", int'(cmd_busy), 1);
      tick(1);
      chk(cmd_busy == 1'b0, "R9 reserved code clears", int'(cmd_busy), 0);
      wr(4'd15); tick(1);
      wr(4'd5);  tick(1);
      set_sys(5, 100);
      count_high(20, h);
      chk(h == 0, "R9 reserved or inapplicable code no pulse", h, 0);
   endtask

   task automatic t_modes();
      int h;
      do_reset(4, 10, 2'd0);
      wr(4'd1); tick(1);
      set_sys(5, 100); tick(1);
      chk(tgt_irq == 1'b1, "R10 mode 0 irq", int'(tgt_irq), 1);
      count_high(10, h);
      chk(h == 0, "R10 mode 0 no pulse", h, 0);
      tgt_mode = 2'd3; tick(1);
      chk(pps_out == 1'b1, "R10 mode 3 starts armed pulse", int'(pps_out), 1);

      do_reset(4, 10, 2'd2);
      wr(4'd1); tick(1);
      set_sys(5, 100); tick(1);
      chk(tgt_irq == 1'b1 && pps_out == 1'b1, "R10 mode 2 irq and pulse",
          int'({tgt_irq, pps_out}), 3);

      do_reset(4, 10, 2'd1);
      wr(4'd1); tick(1);
      set_sys(5, 100); tick(1);
      chk(tgt_irq == 1'b0 && pps_out == 1'b0, "R10 mode 1 neither",
          int'({tgt_irq, pps_out}), 0);
   endtask

   task automatic t_zero_width();
      int h;
      do_reset(0, 10, 2'd3);
      wr(4'd1); tick(1);
      set_sys(5, 100);
      count_high(10, h);
      chk(h == 0, "R13 width 0 no high", h, 0);
      pulse_width = 2;
      set_sys(0, 0);
      wr(4'd1); tick(1);
      set_sys(5, 100);
      count_high(10, h);
      chk(h == 2, "R13 returns idle after width 0", h, 2);
   endtask

   initial begin
      t_reset_state();
      t_match_compare();
      t_single();
      t_busy();
      t_train_stop_now();
      t_stop_at();
      t_cancel_stop();
      t_cancel_start();
      t_reserved();
      t_modes();
      t_zero_width();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule